// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block turns one host request into the complete byte-level command stream of a single SMBus transaction and hands that stream to a byte-oriented I2C master engine. The engine handles the bit-level SCL/SDA timing. The host gives a 7-bit target address, a direction flag, a command byte, a transaction kind and a length. Outgoing data bytes come from a host buffer that the sequencer indexes. Incoming data bytes go back through a write strobe carrying an index.

The sequencer asks the engine for START, repeated START, byte transmissions and STOP. While bytes are being received, it drives a level that tells the engine to withhold acknowledge on the final byte. Each step waits for an engine event. An event is data-ready, bus error or negative acknowledge, and the engine's master-status level is sampled alongside it. Every transaction ends with a one-cycle completion pulse and a result code. A result of I/O error also raises a level telling the surrounding logic that the engine must be reset. A programmable watchdog ends a transaction that stops receiving events.

Top module: `smbus_seq`

## Requirements
- R1: After reset, all of the following are low: `busy`, `done`, `needs_reset`, `rd_we`, `eng_start`, `eng_stop`, `eng_wr`, `eng_flag_clr` and `eng_nack_last`.
- R2: Some requests are rejected with no engine command issued. This covers a read whose effective length is zero, a block length above `MAX_BLOCK`, and a kind code above 4. `done` pulses with `result` 3 on the cycle after acceptance.
- R3: Kind codes are 0 quick, 1 byte, 2 byte-data, 3 word-data and 4 block-data.
  - For kinds 2 to 4, the engine receives START, then the address byte with bit 0 cleared, then the command byte.
  - A read then gets a second START issued together with the address byte with bit 0 set.
  - Kinds 0 and 1 send START and then the address byte with bit 0 equal to `req_read`.
- R4: A byte-kind write sends `req_cmd` as its only data byte. A quick write sends no data byte.
- R5: Data bytes are taken from the host buffer at `wr_idx` 0, 1, 2 and so on.
  - Byte-data carries 1 byte.
  - Word-data carries 2 bytes, index 0 (the low byte) first.
  - Block-data carries `req_len` bytes, from 0 up to `MAX_BLOCK`.
- R6: A data-ready event with no error produces the next engine command or buffer write in the following cycle.
- R7: At each data-ready event in the receive phase, `eng_nack_last` is high exactly when that event delivers the final byte.
- R8: Each received byte appears on `rd_data` with a one-cycle `rd_we`, at `rd_idx` counting up from 0.
- R9: After the final byte's event, one cycle later `eng_stop` and `done` pulse together with `result` 0. For a write, the final event is the one after the last data byte.
- R10: A negative acknowledge while busy gives `eng_stop`, `eng_flag_clr` and `done` with `result` 1 in the next cycle, and leaves `needs_reset` low.
- R11: A bus error, or any event seen while `ev_master` is low, gives `done` with `result` 2 and raises `needs_reset` in the next cycle, with no STOP.
- R12: If no event arrives, `done` with `result` 2 and `needs_reset` set appear `tmo_limit`+1 cycles after acceptance.
- R13: Events are ignored while idle. `needs_reset` holds until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_read | input | 1 | 1 = read transaction |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte |
| req_kind | input | 3 | Transaction kind code |
| req_len | input | LEN_W | Block length |
| tmo_limit | input | TMO_W | Watchdog limit in cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 rejected |
| needs_reset | output | 1 | Engine reset required |
| wr_idx | output | LEN_W | Outgoing buffer index |
| wr_data | input | 8 | Outgoing buffer byte at wr_idx |
| rd_we | output | 1 | Incoming byte strobe |
| rd_idx | output | LEN_W | Incoming byte index |
| rd_data | output | 8 | Incoming byte |
| eng_start | output | 1 | Request START pulse |
| eng_stop | output | 1 | Request STOP pulse |
| eng_wr | output | 1 | Transmit eng_wdata pulse |
| eng_wdata | output | 8 | Byte to transmit |
| eng_nack_last | output | 1 | Withhold acknowledge on byte being received |
| eng_flag_clr | output | 1 | Clear engine NACK and stall flags |
| eng_rdata | input | 8 | Byte received by engine |
| ev_ready | input | 1 | Engine data-ready event |
| ev_berr | input | 1 | Engine bus-error event |
| ev_nack | input | 1 | Engine negative-acknowledge event |
| ev_master | input | 1 | Engine still holds bus master status |

## Verification
Every output is registered, so each response is due exactly one clock after its cause. A rejection answers on the cycle after acceptance. An engine command or buffer write follows one cycle after the event that prompts it. The watchdog abort comes `tmo_limit`+1 cycles after acceptance. The bench drives inputs and samples outputs on the falling edge. Its engine model records each one-cycle pulse in the half-cycle after the edge that produced it. Rejection and watchdog latencies are measured in counted falling edges and compared with exact values.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_RSTART,
      ST_QUICK,
      ST_READ,
      ST_WRITE
   } seq_state_t;

   localparam logic [2:0] KIND_QUICK = 3'd0;
   localparam logic [2:0] KIND_BYTE  = 3'd1;
   localparam logic [2:0] KIND_BDATA = 3'd2;
   localparam logic [2:0] KIND_WORD  = 3'd3;
   localparam logic [2:0] KIND_BLOCK = 3'd4;

   localparam logic [1:0] RES_OK    = 2'd0;
   localparam logic [1:0] RES_NODEV = 2'd1;
   localparam logic [1:0] RES_IOERR = 2'd2;
   localparam logic [1:0] RES_INVAL = 2'd3;

endpackage

// File: rtl/smbus_seq_len.sv
module smbus_seq_len
   import smbus_seq_pkg::*;
#(
   parameter int MAX_BLOCK = 32,
   parameter int LEN_W     = 6
) (
   input  logic [2:0]       kind,
   input  logic             is_read,
   input  logic [LEN_W-1:0] blk_len,
   output logic [LEN_W-1:0] eff_len,
   output logic             cmd_phase,
   output logic             data_is_cmd,
   output logic             reject
);
   localparam logic [LEN_W-1:0] BLK_CAP = LEN_W'(MAX_BLOCK);

   logic bad_kind;
   logic too_long;

   always_comb begin
      eff_len   = '0;
      cmd_phase = 1'b0;
      bad_kind  = 1'b0;
      too_long  = 1'b0;
      unique case (kind)
         KIND_QUICK: eff_len = '0;
         KIND_BYTE:  eff_len = LEN_W'(1);
         KIND_BDATA: begin eff_len = LEN_W'(1); cmd_phase = 1'b1; end
         KIND_WORD:  begin eff_len = LEN_W'(2); cmd_phase = 1'b1; end
         KIND_BLOCK: begin
            eff_len   = blk_len;
            cmd_phase = 1'b1;
            too_long  = (blk_len > BLK_CAP);
         end
         default:    bad_kind = 1'b1;
      endcase
   end

   assign data_is_cmd = (kind == KIND_BYTE) && !is_read;
   assign reject      = bad_kind || too_long || (is_read && (eff_len == '0));

endmodule

// File: rtl/smbus_seq_wdog.sv
module smbus_seq_wdog #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             kick,
   input  logic [TMO_W-1:0] limit,
   output logic             fire
);
   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || kick) begin
         cnt_q <= '0;
      end else if (cnt_q != {TMO_W{1'b1}}) begin
         cnt_q <= cnt_q + TMO_W'(1);
      end
   end

   assign fire = run && !kick && (cnt_q == limit);

endmodule

// File: rtl/smbus_seq_fsm.sv
module smbus_seq_fsm
   import smbus_seq_pkg::*;
#(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_read,
   input  logic [6:0]       req_addr,
   input  logic [7:0]       req_cmd,
   input  logic [LEN_W-1:0] dec_len,
   input  logic             dec_cmd_phase,
   input  logic             dec_data_is_cmd,
   input  logic             dec_reject,
   input  logic             wd_fire,
   output logic             wd_run,
   output logic             wd_kick,
   input  logic [7:0]       wr_data,
   input  logic [7:0]       eng_rdata,
   input  logic             ev_ready,
   input  logic             ev_berr,
   input  logic             ev_nack,
   input  logic             ev_master,
   output logic             busy,
   output logic             done,
   output logic [1:0]       result,
   output logic             needs_reset,
   output logic [LEN_W-1:0] wr_idx,
   output logic             rd_we,
   output logic [LEN_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic             eng_start,
   output logic             eng_stop,
   output logic             eng_wr,
   output logic [7:0]       eng_wdata,
   output logic             eng_nack_last,
   output logic             eng_flag_clr
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
   localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

   seq_state_t       state_q;
   logic [6:0]       addr_q;
   logic [7:0]       cmd_q;
   logic             rd_q;
   logic             from_cmd_q;
   logic [LEN_W-1:0] rem_q;
   logic [LEN_W-1:0] idx_q;
   logic             any_ev;
   logic             hard_err;

   assign any_ev   = ev_ready || ev_berr || ev_nack;
   assign hard_err = ev_berr || !ev_master;
   assign wd_run   = (state_q != ST_IDLE);
   assign wd_kick  = any_ev;
   assign busy     = (state_q != ST_IDLE);
   assign wr_idx   = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         addr_q        <= '0;
         cmd_q         <= '0;
         rd_q          <= 1'b0;
         from_cmd_q    <= 1'b0;
         rem_q         <= '0;
         idx_q         <= '0;
         done          <= 1'b0;
         result        <= RES_OK;
         needs_reset   <= 1'b0;
         rd_we         <= 1'b0;
         rd_idx        <= '0;
         rd_data       <= '0;
         eng_start     <= 1'b0;
         eng_stop      <= 1'b0;
         eng_wr        <= 1'b0;
         eng_wdata     <= '0;
         eng_nack_last <= 1'b0;
         eng_flag_clr  <= 1'b0;
      end else begin
         done         <= 1'b0;
         rd_we        <= 1'b0;
         eng_start    <= 1'b0;
         eng_stop     <= 1'b0;
         eng_wr       <= 1'b0;
         eng_flag_clr <= 1'b0;

         if (state_q == ST_IDLE) begin
            if (req_valid) begin
               needs_reset <= 1'b0;
               if (dec_reject) begin
                  done   <= 1'b1;
                  result <= RES_INVAL;
               end else begin
                  addr_q        <= req_addr;
                  cmd_q         <= req_cmd;
                  rd_q          <= req_read;
                  from_cmd_q    <= dec_data_is_cmd;
                  rem_q         <= dec_len;
                  idx_q         <= '0;
                  eng_nack_last <= 1'b0;
                  eng_start     <= 1'b1;
                  state_q       <= dec_cmd_phase ? ST_ADDR : ST_QUICK;
               end
            end
         end else if (wd_fire || (any_ev && hard_err)) begin
            state_q       <= ST_IDLE;
            done          <= 1'b1;
            result        <= RES_IOERR;
            needs_reset   <= 1'b1;
            eng_nack_last <= 1'b0;
         end else if (ev_nack) begin
            state_q       <= ST_IDLE;
            done          <= 1'b1;
            result        <= RES_NODEV;
            eng_stop      <= 1'b1;
            eng_flag_clr  <= 1'b1;
            eng_nack_last <= 1'b0;
         end else if (ev_ready) begin
            unique case (state_q)
               ST_ADDR: begin
                  eng_wr    <= 1'b1;
                  eng_wdata <= {addr_q, 1'b0};
                  state_q   <= ST_CMD;
               end
               ST_CMD: begin
                  eng_wr    <= 1'b1;
                  eng_wdata <= cmd_q;
                  state_q   <= rd_q ? ST_RSTART : ST_WRITE;
               end
               ST_RSTART, ST_QUICK: begin
                  // repeated START shares the address step of the short kinds
                  if (state_q == ST_RSTART) eng_start <= 1'b1;
                  eng_wr    <= 1'b1;
                  eng_wdata <= {addr_q, rd_q};
                  if (rd_q) begin
                     eng_nack_last <= (rem_q == ONE);
                     state_q       <= ST_READ;
                  end else begin
                     state_q <= ST_WRITE;
                  end
               end
               ST_READ: begin
                  rd_we   <= 1'b1;
                  rd_idx  <= idx_q;
                  rd_data <= eng_rdata;
                  idx_q   <= idx_q + ONE;
                  rem_q   <= rem_q - ONE;
                  if (rem_q == ONE) begin
                     eng_nack_last <= 1'b0;
                     eng_stop      <= 1'b1;
                     done          <= 1'b1;
                     result        <= RES_OK;
                     state_q       <= ST_IDLE;
                  end else begin
                     eng_nack_last <= (rem_q == TWO);
                  end
               end
               ST_WRITE: begin
                  if (rem_q == '0) begin
                     eng_stop <= 1'b1;
                     done     <= 1'b1;
                     result   <= RES_OK;
                     state_q  <= ST_IDLE;
                  end else begin
                     eng_wr    <= 1'b1;
                     eng_wdata <= from_cmd_q ? cmd_q : wr_data;
                     idx_q     <= idx_q + ONE;
                     rem_q     <= rem_q - ONE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
   import smbus_seq_pkg::*;
#(
   parameter int MAX_BLOCK = 32,
   parameter int TMO_W     = 16,
   localparam int LEN_W    = $clog2(MAX_BLOCK + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_read,
   input  logic [6:0]       req_addr,
   input  logic [7:0]       req_cmd,
   input  logic [2:0]       req_kind,
   input  logic [LEN_W-1:0] req_len,
   input  logic [TMO_W-1:0] tmo_limit,
   output logic             busy,
   output logic             done,
   output logic [1:0]       result,
   output logic             needs_reset,
   output logic [LEN_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   output logic             rd_we,
   output logic [LEN_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic             eng_start,
   output logic             eng_stop,
   output logic             eng_wr,
   output logic [7:0]       eng_wdata,
   output logic             eng_nack_last,
   output logic             eng_flag_clr,
   input  logic [7:0]       eng_rdata,
   input  logic             ev_ready,
   input  logic             ev_berr,
   input  logic             ev_nack,
   input  logic             ev_master
);
   generate
      if (MAX_BLOCK < 2) begin : g_bad_block
         $error("smbus_seq: MAX_BLOCK must be at least 2");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("smbus_seq: TMO_W must be at least 2");
      end
   endgenerate

   logic [LEN_W-1:0] dec_len;
   logic             dec_cmd_phase;
   logic             dec_data_is_cmd;
   logic             dec_reject;
   logic             wd_run;
   logic             wd_kick;
   logic             wd_fire;

   smbus_seq_len #(.MAX_BLOCK(MAX_BLOCK), .LEN_W(LEN_W)) u_len (
      .kind        (req_kind),
      .is_read     (req_read),
      .blk_len     (req_len),
      .eff_len     (dec_len),
      .cmd_phase   (dec_cmd_phase),
      .data_is_cmd (dec_data_is_cmd),
      .reject      (dec_reject)
   );

   smbus_seq_wdog #(.TMO_W(TMO_W)) u_wdog (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (wd_run),
      .kick  (wd_kick),
      .limit (tmo_limit),
      .fire  (wd_fire)
   );

   smbus_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid       (req_valid),
      .req_read        (req_read),
      .req_addr        (req_addr),
      .req_cmd         (req_cmd),
      .dec_len         (dec_len),
      .dec_cmd_phase   (dec_cmd_phase),
      .dec_data_is_cmd (dec_data_is_cmd),
      .dec_reject      (dec_reject),
      .wd_fire         (wd_fire),
      .wd_run          (wd_run),
      .wd_kick         (wd_kick),
      .wr_data         (wr_data),
      .eng_rdata       (eng_rdata),
      .ev_ready        (ev_ready),
      .ev_berr         (ev_berr),
      .ev_nack         (ev_nack),
      .ev_master       (ev_master),
      .busy            (busy),
      .done            (done),
      .result          (result),
      .needs_reset     (needs_reset),
      .wr_idx          (wr_idx),
      .rd_we           (rd_we),
      .rd_idx          (rd_idx),
      .rd_data         (rd_data),
      .eng_start       (eng_start),
      .eng_stop        (eng_stop),
      .eng_wr          (eng_wr),
      .eng_wdata       (eng_wdata),
      .eng_nack_last   (eng_nack_last),
      .eng_flag_clr    (eng_flag_clr)
   );

endmodule

// File: rtl/smbus_seq_chk.sv
module smbus_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       busy,
   input logic       done,
   input logic [1:0] result,
   input logic       needs_reset,
   input logic       eng_start,
   input logic       eng_stop,
   input logic       eng_wr,
   input logic       eng_flag_clr,
   input logic       rd_we,
   input logic       ev_ready,
   input logic       ev_berr,
   input logic       ev_nack,
   input logic       ev_master
);
   p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == 2'd3) |-> (!eng_start && !eng_wr && $past(!busy)));

   p_start_not_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_start && eng_stop));

   p_wr_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_wr |-> busy);

   p_ready_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ev_ready && !ev_berr && !ev_nack && ev_master)
      |=> (eng_wr || eng_stop || rd_we));

   p_stop_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_stop |-> (done && !busy));

   p_nack_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ev_nack && !ev_berr && ev_master)
      |=> (eng_stop && eng_flag_clr && done && result == 2'd1 && !needs_reset));

   p_err_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (ev_berr || ((ev_ready || ev_nack) && !ev_master)))
      |=> (done && result == 2'd2 && needs_reset && !eng_stop));

   p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> (!eng_start && !eng_wr && !done && !busy));

endmodule

bind smbus_seq smbus_seq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .busy         (busy),
   .done         (done),
   .result       (result),
   .needs_reset  (needs_reset),
   .eng_start    (eng_start),
   .eng_stop     (eng_stop),
   .eng_wr       (eng_wr),
   .eng_flag_clr (eng_flag_clr),
   .rd_we        (rd_we),
   .ev_ready     (ev_ready),
   .ev_berr      (ev_berr),
   .ev_nack      (ev_nack),
   .ev_master    (ev_master)
);

// File: tb/smbus_seq_tb_top.sv
`timescale 1ns/1ps
module smbus_seq_tb_top;
   localparam int MAXB  = 32;
   localparam int LW    = $clog2(MAXB + 2);
   localparam int TW    = 16;
   localparam int DLY   = 3;

   typedef struct packed {
      logic [2:0]  kind;
      logic        rd;
      logic [5:0]  len;
      logic [1:0]  err;   // 0 none, 1 nack, 2 bus error, 3 master lost
      logic [3:0]  at;    // 1-based event index of the injected error
      logic [1:0]  res;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 1'b0, 6'd0,  2'd0, 4'd0, 2'd0},
      '{3'd1, 1'b0, 6'd0,  2'd0, 4'd0, 2'd0},
      '{3'd1, 1'b1, 6'd0,  2'd0, 4'd0, 2'd0},
      '{3'd2, 1'b0, 6'd0,  2'd0, 4'd0, 2'd0},
      '{3'd2, 1'b1, 6'd0,  2'd0, 4'd0, 2'd0},
      '{3'd3, 1'b0, 6'd0,  2'd0, 4'd0, 2'd0},
      '{3'd3, 1'b1, 6'd0,  2'd0, 4'd0, 2'd0},
      '{3'd4, 1'b0, 6'd5,  2'd0, 4'd0, 2'd0},
      '{3'd4, 1'b0, 6'd0,  2'd0, 4'd0, 2'd0},
      '{3'd4, 1'b1, 6'd4,  2'd0, 4'd0, 2'd0},
      '{3'd4, 1'b0, 6'd32, 2'd0, 4'd0, 2'd0},
      '{3'd2, 1'b0, 6'd0,  2'd1, 4'd2, 2'd1},
      '{3'd3, 1'b1, 6'd0,  2'd1, 4'd4, 2'd1},
      '{3'd4, 1'b0, 6'd3,  2'd2, 4'd3, 2'd2},
      '{3'd1, 1'b1, 6'd0,  2'd3, 4'd1, 2'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_read = 1'b0;
   logic [6:0]    req_addr = '0;
   logic [7:0]    req_cmd = '0;
   logic [2:0]    req_kind = '0;
   logic [LW-1:0] req_len = '0;
   logic [TW-1:0] tmo_limit = TW'(50);
   logic          busy, done, needs_reset, rd_we;
   logic [1:0]    result;
   logic [LW-1:0] wr_idx, rd_idx;
   logic [7:0]    wr_data, rd_data, eng_wdata;
   logic [7:0]    eng_rdata = '0;
   logic          eng_start, eng_stop, eng_wr, eng_nack_last, eng_flag_clr;
   logic          ev_ready = 1'b0, ev_berr = 1'b0, ev_nack = 1'b0, ev_master = 1'b1;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign wr_data = 8'h10 + 8'(wr_idx);

   smbus_seq #(.MAX_BLOCK(MAXB), .TMO_W(TW)) dut_i (.*);

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // engine model state
   int        pend = 0, evidx = 0, rdk = 0, starts = 0, stops = 0, nwr = 0, nclr = 0;
   bit        after_start = 0, reading = 0, mute = 0;
   logic [7:0] wlog [0:47];
   int        cur_len = 0, cur_err = 0, cur_at = 0;

   always @(negedge clk) begin
      ev_ready  = 1'b0;
      ev_nack   = 1'b0;
      ev_berr   = 1'b0;
      ev_master = 1'b1;
      if (eng_flag_clr) nclr++;
      if (eng_start) begin starts++; after_start = 1; pend = DLY; end
      if (eng_wr) begin
         if (nwr < 48) wlog[nwr] = eng_wdata;
         nwr++;
         if (after_start && eng_wdata[0]) reading = 1;
         after_start = 0;
         pend = DLY;
      end
      if (rd_we) begin
         check(rd_data == 8'hA0 + 8'(rd_idx), "R8 rd_data", rd_data, 8'hA0 + rd_idx);
      end
      if (eng_stop) begin stops++; pend = 0; reading = 0; end
      else if (pend > 0) begin
         pend--;
         if (pend == 0 && !mute) begin
            evidx++;
            if (cur_err != 0 && evidx == cur_at) begin
               if (cur_err == 1) ev_nack = 1'b1;
               else if (cur_err == 2) ev_berr = 1'b1;
               else begin ev_ready = 1'b1; ev_master = 1'b0; end
            end else begin
               ev_ready = 1'b1;
               if (reading) begin
                  eng_rdata = 8'hA0 + 8'(rdk);
                  check(eng_nack_last == (rdk == cur_len - 1), "R7 nack_last",
                        eng_nack_last, (rdk == cur_len - 1));
                  rdk++;
                  pend = DLY;
               end
            end
         end
      end
   end

   task automatic clear_model();
      pend = 0; evidx = 0; rdk = 0; starts = 0; stops = 0; nwr = 0; nclr = 0;
      after_start = 0; reading = 0;
   endtask

   // issue at a falling edge; returns at the next falling edge
   task automatic send(input logic [2:0] k, input logic r, input int l,
                       input logic [6:0] a, input logic [7:0] c);
      req_kind = k; req_read = r; req_len = LW'(l); req_addr = a; req_cmd = c;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 1;
      while (!done && n < 3000) begin @(negedge clk); n++; end
   endtask

   task automatic run_vec(input int i);
      vec_t v;
      int n, ne, el;
      logic [7:0] exp [0:47];
      logic [6:0] a;
      logic [7:0] c;
      v = VECS[i];
      a = 7'h20 + 7'(i);
      c = 8'h40 + 8'(i);
      el = (v.kind == 3'd0) ? 0 : (v.kind == 3'd3) ? 2 : (v.kind == 3'd4) ? int'(v.len) : 1;
      clear_model();
      cur_len = el; cur_err = int'(v.err); cur_at = int'(v.at);
      ne = 0;
      if (v.kind >= 3'd2) begin
         exp[ne++] = {a, 1'b0};
         exp[ne++] = c;
         if (v.rd) exp[ne++] = {a, 1'b1};
         else for (int j = 0; j < el; j++) exp[ne++] = 8'h10 + 8'(j);
      end else begin
         exp[ne++] = {a, v.rd};
         if (v.kind == 3'd1 && !v.rd) exp[ne++] = c;
      end
      send(v.kind, v.rd, int'(v.len), a, c);
      wait_done(n);
      check(done === 1'b1 && result == v.res, "R9/R10/R11 result", result, v.res);
      check(needs_reset == (v.res == 2'd2), "R11 needs_reset", needs_reset, (v.res == 2'd2));
      @(negedge clk);
      if (v.res == 2'd0) begin
         check(nwr == ne, "R3/R4/R5 byte count", nwr, ne);
         for (int j = 0; j < ne && j < nwr; j++)
            check(wlog[j] == exp[j], "R3/R4/R5 byte value", wlog[j], exp[j]);
         check(starts == ((v.kind >= 3'd2 && v.rd) ? 2 : 1), "R3 starts", starts,
               (v.kind >= 3'd2 && v.rd) ? 2 : 1);
         check(stops == 1, "R9 stop", stops, 1);
         if (v.rd) check(rdk == el, "R8 read count", rdk, el);
      end else if (v.res == 2'd1) begin
         check(stops == 1 && nclr == 1, "R10 stop and flag clear", stops + nclr, 2);
      end else begin
         check(stops == 0, "R11 no stop", stops, 0);
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(8ns * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({busy, done, needs_reset, rd_we, eng_start, eng_stop, eng_wr,
             eng_flag_clr, eng_nack_last} == '0, "R1 reset outputs", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(i);

      // R2 rejections: zero-length reads, oversize block, undefined kind
      clear_model();
      send(3'd4, 1'b1, 0, 7'h11, 8'h00); wait_done(n);
      check(n == 1 && result == 2'd3, "R2 block read len 0", n, 1);
      send(3'd0, 1'b1, 0, 7'h11, 8'h00); wait_done(n);
      check(n == 1 && result == 2'd3, "R2 quick read", n, 1);
      send(3'd4, 1'b0, 33, 7'h11, 8'h00); wait_done(n);
      check(n == 1 && result == 2'd3, "R2 block len 33", n, 1);
      send(3'd6, 1'b0, 1, 7'h11, 8'h00); wait_done(n);
      check(n == 1 && result == 2'd3, "R2 bad kind", n, 1);
      repeat (6) @(negedge clk);
      check(starts == 0 && nwr == 0, "R2 no bus activity", starts + nwr, 0);

      // R12 watchdog: engine silent
      mute = 1; clear_model();
      tmo_limit = TW'(20);
      send(3'd2, 1'b0, 0, 7'h33, 8'h01); wait_done(n);
      check(n == 22, "R12 timeout latency", n, 22);
      check(result == 2'd2 && needs_reset, "R12 timeout result", result, 2);
      mute = 0;
      repeat (4) @(negedge clk);

      // R13 idle events ignored, needs_reset held
      clear_model();
      eng_rdata = 8'h55;
      repeat (5) @(negedge clk);
      force ev_ready = 1'b1;
      @(negedge clk);
      release ev_ready;
      force ev_nack = 1'b1;
      @(negedge clk);
      release ev_nack;
      repeat (3) @(negedge clk);
      check(starts == 0 && nwr == 0 && stops == 0 && !busy, "R13 idle ignores events",
            starts + nwr + stops, 0);
      check(needs_reset == 1'b1, "R13 needs_reset held", needs_reset, 1);

      // R13/R6 next accepted request clears needs_reset and completes
      tmo_limit = TW'(50);
      clear_model(); cur_len = 1; cur_err = 0;
      send(3'd1, 1'b0, 0, 7'h44, 8'h9C);
      check(needs_reset == 1'b0, "R13 needs_reset cleared", needs_reset, 0);
      wait_done(n);
      check(result == 2'd0, "R6 byte write after abort", result, 0);

      repeat (5) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule